// File: doc/BRIEF.md
# Banked data memory address mapper

This block sits between a small processor's operand-address logic and its data store. The data space has four banks of 128 byte locations each. Every access arrives in one of two forms. A direct access carries a 7-bit in-bank offset from the instruction, and two bank-select status bits choose the bank. An indirect access carries an 8-bit pointer and one extra status bit. The extra bit and the pointer's top bit choose the bank, and the pointer's low seven bits give the offset.

Once the bank and offset are known, the block sorts the location into a region. Low offsets belong to the special-function registers, which live outside the block. They are reached through a port that carries a 9-bit register address. A parameter lists the frequently used registers that are mirrored: these always reach the bank-0 copy, whatever bank was selected. The top sixteen offsets of every bank map to one shared area. The offsets in between are private general-purpose RAM, held in the block's own storage. A parameter mask says which banks have private RAM. In a bank without it, that range reads as zero and ignores writes.

Writes take effect on the clock edge when the write enable is high. Reads are combinational from the current address. A synchronous active-high reset clears all internal RAM.

Top module: `banked_dmem_mapper`

## Requirements
- R1: In direct mode (`indirect_i`=0) the bank is `rp_i` (0 to 3) and the offset is `dir_offs_i`; a non-mirrored special register is addressed as `sfr_addr_o` = {rp_i, dir_offs_i}.
- R2: In indirect mode (`indirect_i`=1) the bank is {`irp_i`, `ptr_i[7]`} and the offset is `ptr_i[6:0]`; `rp_i` and `dir_offs_i` have no effect.
- R3: Offsets 70h to 7Fh reach one shared 16-byte area: a write there in any bank, by either mode, is read back from the same offset in every bank.
- R4: Offsets below 20h raise `sfr_sel_o`, put the offset in `sfr_addr_o[6:0]` and return `sfr_rdata_i` on `rdata_o`; internal RAM is not written.
- R5: The mirrored offsets 00h, 02h, 03h, 04h, 0Ah and 0Bh give `sfr_addr_o[8:7]` = 00 in every bank; other special offsets keep the selected bank in `sfr_addr_o[8:7]`.
- R6: Offsets 20h to 6Fh of banks 0 and 1 are private RAM: the same offset in the two banks holds independent bytes.
- R7: Offsets 20h to 6Fh of banks 2 and 3 are not implemented: they read 0, writes to them change nothing, and `sfr_sel_o` stays low.
- R8: A write lands on the rising clock edge with `wr_en_i` high; during the write cycle `rdata_o` still shows the old byte, and from the next cycle it shows the new one.
- R9: After synchronous reset every private and shared RAM byte reads 0.
- R10: `sfr_we_o` is high only when `wr_en_i` is high and the access is a special-register access; `sfr_wdata_o` carries `wdata_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears internal RAM |
| indirect_i | input | 1 | 1 selects indirect (pointer) addressing |
| rp_i | input | 2 | Bank select for direct mode |
| irp_i | input | 1 | Upper bank bit for indirect mode |
| dir_offs_i | input | 7 | In-bank offset from the instruction |
| ptr_i | input | 8 | Pointer for indirect mode |
| wr_en_i | input | 1 | Write strobe for the current access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the mapped location |
| sfr_sel_o | output | 1 | Access targets a special register |
| sfr_we_o | output | 1 | Write strobe to the special-register file |
| sfr_addr_o | output | 9 | Special-register address {bank, offset}; bank 00 for mirrored registers |
| sfr_wdata_o | output | 8 | Write data to the special-register file |
| sfr_rdata_i | input | 8 | Read data from the special-register file |

## Verification
The bench first probes the boundary offsets 1Fh/20h and 6Fh/70h. A wrong region compare there would send RAM traffic to the register port, or split the shared area per bank. It then checks pointer bit 7 together with the extra status bit, since a mapper that ignores either one aliases two banks onto one. Mirrored and non-mirrored register offsets are tried in banks 1 to 3; a mirror fault shows up as a wrong bank field on `sfr_addr_o`. Writes go to the unimplemented banks and are read back, which exposes any storage that leaks or aliases into bank 0 or 1.

// File: rtl/dmem_map_pkg.sv
package dmem_map_pkg;

    localparam int BANK_W     = 2;
    localparam int OFFS_W     = 7;
    localparam int PTR_W      = OFFS_W + 1;
    localparam int NUM_BANKS  = 1 << BANK_W;
    localparam int BANK_SPAN  = 1 << OFFS_W;
    localparam int SFR_ADDR_W = BANK_W + OFFS_W;

    typedef logic [BANK_W-1:0]     bank_t;
    typedef logic [OFFS_W-1:0]     offs_t;
    typedef logic [SFR_ADDR_W-1:0] sfr_addr_t;

    typedef enum logic [1:0] {
        RGN_SFR    = 2'd0,
        RGN_PRIV   = 2'd1,
        RGN_SHARED = 2'd2,
        RGN_VOID   = 2'd3
    } region_e;

    typedef struct packed {
        region_e region;
        bank_t   bank;
        offs_t   offs;
        logic    mirrored;
    } loc_t;

    // membership of an offset in a 32-entry offset mask
    function automatic logic offs_in_mask(input logic [31:0] mask, input offs_t o);
        return (o[OFFS_W-1:5] == '0) ? mask[o[4:0]] : 1'b0;
    endfunction

    function automatic logic region_is_ram(input region_e r);
        return (r == RGN_PRIV) || (r == RGN_SHARED);
    endfunction

endpackage

// File: rtl/dmem_loc_decode.sv
module dmem_loc_decode
    import dmem_map_pkg::*;
#(
    parameter int          SFR_LIMIT      = 32,
    parameter int          SHARED_BASE    = 112,
    parameter logic [31:0] MIRROR_MASK    = 32'h0000_0C1D,
    parameter logic [3:0]  PRIV_BANK_MASK = 4'b0011
) (
    input  logic             indirect_i,
    input  bank_t            rp_i,
    input  logic             irp_i,
    input  offs_t            dir_offs_i,
    input  logic [PTR_W-1:0] ptr_i,
    output loc_t             loc_o
);

    localparam offs_t SFR_LIM_O = offs_t'(SFR_LIMIT);
    localparam offs_t SH_BASE_O = offs_t'(SHARED_BASE);

    bank_t bank_sel;
    offs_t offs_sel;

    // mode selects where bank and offset come from
    always_comb begin
        if (indirect_i) begin
            bank_sel = {irp_i, ptr_i[PTR_W-1]};
            offs_sel = ptr_i[OFFS_W-1:0];
        end else begin
            bank_sel = rp_i;
            offs_sel = dir_offs_i;
        end
    end

    always_comb begin
        loc_o.bank     = bank_sel;
        loc_o.offs     = offs_sel;
        loc_o.mirrored = 1'b0;
        if (offs_sel >= SH_BASE_O) begin
            loc_o.region = RGN_SHARED;
        end else if (offs_sel < SFR_LIM_O) begin
            loc_o.region   = RGN_SFR;
            loc_o.mirrored = offs_in_mask(MIRROR_MASK, offs_sel);
        end else if (PRIV_BANK_MASK[bank_sel]) begin
            loc_o.region = RGN_PRIV;
        end else begin
            loc_o.region = RGN_VOID;
        end
    end

endmodule

// File: rtl/dmem_gpr_store.sv
module dmem_gpr_store
    import dmem_map_pkg::*;
#(
    parameter int         DATA_W         = 8,
    parameter int         SFR_LIMIT      = 32,
    parameter int         SHARED_BASE    = 112,
    parameter logic [3:0] PRIV_BANK_MASK = 4'b0011
) (
    input  logic              clk,
    input  logic              rst,
    input  loc_t              loc_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int    PRIV_DEPTH   = SHARED_BASE - SFR_LIMIT;
    localparam int    SHARED_DEPTH = BANK_SPAN - SHARED_BASE;
    localparam int    PV_IDX_W     = $clog2(PRIV_DEPTH);
    localparam int    SH_IDX_W     = $clog2(SHARED_DEPTH);
    localparam offs_t SFR_LIM_O    = offs_t'(SFR_LIMIT);
    localparam offs_t SH_BASE_O    = offs_t'(SHARED_BASE);

    logic [PV_IDX_W-1:0] pv_idx;
    logic [SH_IDX_W-1:0] sh_idx;
    logic                priv_hit;
    logic                shared_hit;

    assign priv_hit   = (loc_i.region == RGN_PRIV);
    assign shared_hit = (loc_i.region == RGN_SHARED);
    assign pv_idx     = priv_hit   ? PV_IDX_W'(loc_i.offs - SFR_LIM_O) : '0;
    assign sh_idx     = shared_hit ? SH_IDX_W'(loc_i.offs - SH_BASE_O) : '0;

    // one shared area seen from every bank
    logic [DATA_W-1:0] shared_q [SHARED_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SHARED_DEPTH; i++) shared_q[i] <= '0;
        end else if (we_i && shared_hit) begin
            shared_q[sh_idx] <= wdata_i;
        end
    end

    // private storage, built only for banks enabled in the mask
    logic [DATA_W-1:0] bank_rd [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        if (PRIV_BANK_MASK[b]) begin : g_impl
            logic [DATA_W-1:0] priv_q [PRIV_DEPTH];
            logic              bank_we;

            assign bank_we = we_i && priv_hit && (loc_i.bank == bank_t'(b));

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < PRIV_DEPTH; i++) priv_q[i] <= '0;
                end else if (bank_we) begin
                    priv_q[pv_idx] <= wdata_i;
                end
            end

            assign bank_rd[b] = priv_q[pv_idx];
        end else begin : g_absent
            assign bank_rd[b] = '0;
        end
    end

    always_comb begin
        case (loc_i.region)
            RGN_SHARED: rdata_o = shared_q[sh_idx];
            RGN_PRIV:   rdata_o = bank_rd[loc_i.bank];
            default:    rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/dmem_sfr_route.sv
module dmem_sfr_route
    import dmem_map_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  loc_t              loc_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] ram_rdata_i,
    input  logic [DATA_W-1:0] sfr_rdata_i,
    output logic              ram_we_o,
    output logic              sfr_sel_o,
    output logic              sfr_we_o,
    output sfr_addr_t         sfr_addr_o,
    output logic [DATA_W-1:0] sfr_wdata_o,
    output logic [DATA_W-1:0] rdata_o
);

    logic  is_sfr;
    bank_t canon_bank;

    assign is_sfr     = (loc_i.region == RGN_SFR);
    assign canon_bank = loc_i.mirrored ? bank_t'(0) : loc_i.bank;

    assign sfr_sel_o   = is_sfr;
    assign sfr_we_o    = is_sfr && wr_en_i;
    assign sfr_addr_o  = is_sfr ? {canon_bank, loc_i.offs} : '0;
    assign sfr_wdata_o = wdata_i;
    assign ram_we_o    = wr_en_i && region_is_ram(loc_i.region);

    always_comb begin
        if (is_sfr)                          rdata_o = sfr_rdata_i;
        else if (region_is_ram(loc_i.region)) rdata_o = ram_rdata_i;
        else                                 rdata_o = '0;
    end

endmodule

// File: rtl/banked_dmem_mapper.sv
module banked_dmem_mapper
    import dmem_map_pkg::*;
#(
    parameter int          DATA_W         = 8,
    parameter int          SFR_LIMIT      = 32,
    parameter int          SHARED_BASE    = 112,
    parameter logic [31:0] MIRROR_MASK    = 32'h0000_0C1D,
    parameter logic [3:0]  PRIV_BANK_MASK = 4'b0011
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  indirect_i,
    input  logic [BANK_W-1:0]     rp_i,
    input  logic                  irp_i,
    input  logic [OFFS_W-1:0]     dir_offs_i,
    input  logic [PTR_W-1:0]      ptr_i,
    input  logic                  wr_en_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output logic [DATA_W-1:0]     rdata_o,
    output logic                  sfr_sel_o,
    output logic                  sfr_we_o,
    output logic [SFR_ADDR_W-1:0] sfr_addr_o,
    output logic [DATA_W-1:0]     sfr_wdata_o,
    input  logic [DATA_W-1:0]     sfr_rdata_i
);

    loc_t              loc;
    logic              ram_we;
    logic [DATA_W-1:0] ram_rdata;

    dmem_loc_decode #(
        .SFR_LIMIT      (SFR_LIMIT),
        .SHARED_BASE    (SHARED_BASE),
        .MIRROR_MASK    (MIRROR_MASK),
        .PRIV_BANK_MASK (PRIV_BANK_MASK)
    ) i_decode (
        .indirect_i (indirect_i),
        .rp_i       (rp_i),
        .irp_i      (irp_i),
        .dir_offs_i (dir_offs_i),
        .ptr_i      (ptr_i),
        .loc_o      (loc)
    );

    dmem_gpr_store #(
        .DATA_W         (DATA_W),
        .SFR_LIMIT      (SFR_LIMIT),
        .SHARED_BASE    (SHARED_BASE),
        .PRIV_BANK_MASK (PRIV_BANK_MASK)
    ) i_store (
        .clk     (clk),
        .rst     (rst),
        .loc_i   (loc),
        .we_i    (ram_we),
        .wdata_i (wdata_i),
        .rdata_o (ram_rdata)
    );

    dmem_sfr_route #(
        .DATA_W (DATA_W)
    ) i_route (
        .loc_i       (loc),
        .wr_en_i     (wr_en_i),
        .wdata_i     (wdata_i),
        .ram_rdata_i (ram_rdata),
        .sfr_rdata_i (sfr_rdata_i),
        .ram_we_o    (ram_we),
        .sfr_sel_o   (sfr_sel_o),
        .sfr_we_o    (sfr_we_o),
        .sfr_addr_o  (sfr_addr_o),
        .sfr_wdata_o (sfr_wdata_o),
        .rdata_o     (rdata_o)
    );

endmodule

// File: rtl/dmem_map_chk.sv
module dmem_map_chk
    import dmem_map_pkg::*;
#(
    parameter int          DATA_W         = 8,
    parameter int          SFR_LIMIT      = 32,
    parameter int          SHARED_BASE    = 112,
    parameter logic [31:0] MIRROR_MASK    = 32'h0000_0C1D,
    parameter logic [3:0]  PRIV_BANK_MASK = 4'b0011
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  indirect_i,
    input logic [BANK_W-1:0]     rp_i,
    input logic                  irp_i,
    input logic [OFFS_W-1:0]     dir_offs_i,
    input logic [PTR_W-1:0]      ptr_i,
    input logic                  wr_en_i,
    input logic [DATA_W-1:0]     wdata_i,
    input logic [DATA_W-1:0]     rdata_o,
    input logic                  sfr_sel_o,
    input logic                  sfr_we_o,
    input logic [SFR_ADDR_W-1:0] sfr_addr_o,
    input logic [DATA_W-1:0]     sfr_wdata_o,
    input logic [DATA_W-1:0]     sfr_rdata_i
);

    localparam offs_t SFR_LIM_O = offs_t'(SFR_LIMIT);
    localparam offs_t SH_BASE_O = offs_t'(SHARED_BASE);

    bank_t eff_bank;
    offs_t eff_offs;
    logic  ram_loc;
    logic  void_loc;
    logic  port_mirror;
    logic  past_ok;

    assign eff_bank    = indirect_i ? {irp_i, ptr_i[PTR_W-1]} : rp_i;
    assign eff_offs    = indirect_i ? ptr_i[OFFS_W-1:0] : dir_offs_i;
    assign ram_loc     = (eff_offs >= SH_BASE_O) ||
                         ((eff_offs >= SFR_LIM_O) && PRIV_BANK_MASK[eff_bank]);
    assign void_loc    = (eff_offs >= SFR_LIM_O) && (eff_offs < SH_BASE_O) &&
                         !PRIV_BANK_MASK[eff_bank];
    assign port_mirror = offs_in_mask(MIRROR_MASK, sfr_addr_o[OFFS_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    p_direct_bank_r1: assert property (@(posedge clk) disable iff (rst)
        (sfr_sel_o && !indirect_i && !port_mirror) |-> (sfr_addr_o[SFR_ADDR_W-1:OFFS_W] == rp_i));

    p_indirect_bank_r2: assert property (@(posedge clk) disable iff (rst)
        (sfr_sel_o && indirect_i && !port_mirror)
            |-> (sfr_addr_o[SFR_ADDR_W-1:OFFS_W] == {irp_i, ptr_i[PTR_W-1]}));

    p_sfr_route_r4: assert property (@(posedge clk) disable iff (rst)
        (eff_offs < SFR_LIM_O)
            |-> (sfr_sel_o && rdata_o == sfr_rdata_i && sfr_addr_o[OFFS_W-1:0] == eff_offs));

    p_mirror_bank0_r5: assert property (@(posedge clk) disable iff (rst)
        (sfr_sel_o && port_mirror) |-> (sfr_addr_o[SFR_ADDR_W-1:OFFS_W] == '0));

    p_void_zero_r7: assert property (@(posedge clk) disable iff (rst)
        void_loc |-> (rdata_o == '0 && !sfr_sel_o));

    p_write_visible_r8: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !wr_en_i && $past(wr_en_i && ram_loc) &&
         eff_bank == $past(eff_bank) && eff_offs == $past(eff_offs))
            |-> (rdata_o == $past(wdata_i)));

    p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && ram_loc) |-> (rdata_o == '0));

    p_sfr_we_gate_r10: assert property (@(posedge clk) disable iff (rst)
        sfr_we_o |-> (wr_en_i && sfr_sel_o && sfr_wdata_o == wdata_i));

endmodule

bind banked_dmem_mapper dmem_map_chk #(
    .DATA_W         (DATA_W),
    .SFR_LIMIT      (SFR_LIMIT),
    .SHARED_BASE    (SHARED_BASE),
    .MIRROR_MASK    (MIRROR_MASK),
    .PRIV_BANK_MASK (PRIV_BANK_MASK)
) i_chk (
    .clk         (clk),
    .rst         (rst),
    .indirect_i  (indirect_i),
    .rp_i        (rp_i),
    .irp_i       (irp_i),
    .dir_offs_i  (dir_offs_i),
    .ptr_i       (ptr_i),
    .wr_en_i     (wr_en_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .sfr_sel_o   (sfr_sel_o),
    .sfr_we_o    (sfr_we_o),
    .sfr_addr_o  (sfr_addr_o),
    .sfr_wdata_o (sfr_wdata_o),
    .sfr_rdata_i (sfr_rdata_i)
);

// File: tb/test_banked_dmem_mapper.sv
module test_banked_dmem_mapper;

    localparam time CLK_P = 8ns;

    logic       clk = 1'b0;
    logic       rst;
    logic       indirect;
    logic [1:0] rp;
    logic       irp;
    logic [6:0] doff;
    logic [7:0] ptr;
    logic       wr_en;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       sfr_sel;
    logic       sfr_we;
    logic [8:0] sfr_addr;
    logic [7:0] sfr_wdata;
    logic [7:0] sfr_rdata;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done     = 1'b0;

    // reference model state
    logic [7:0] shared_m [16];
    logic [7:0] priv_m   [4][128];

    always #(CLK_P/2) clk = ~clk;

    // external register file stand-in: data depends on the address it sees
    assign sfr_rdata = sfr_addr[7:0] ^ 8'h5A;

    banked_dmem_mapper i_banked_dmem_mapper (
        .clk         (clk),
        .rst         (rst),
        .indirect_i  (indirect),
        .rp_i        (rp),
        .irp_i       (irp),
        .dir_offs_i  (doff),
        .ptr_i       (ptr),
        .wr_en_i     (wr_en),
        .wdata_i     (wdata),
        .rdata_o     (rdata),
        .sfr_sel_o   (sfr_sel),
        .sfr_we_o    (sfr_we),
        .sfr_addr_o  (sfr_addr),
        .sfr_wdata_o (sfr_wdata),
        .sfr_rdata_i (sfr_rdata)
    );

    function automatic bit is_mirror(input int o);
        case (o)
            'h00, 'h02, 'h03, 'h04, 'h0A, 'h0B: return 1'b1;
            default:                             return 1'b0;
        endcase
    endfunction

    function automatic void clear_model();
        for (int i = 0; i < 16; i++) shared_m[i] = 8'h00;
        for (int b = 0; b < 4; b++)
            for (int i = 0; i < 128; i++) priv_m[b][i] = 8'h00;
    endfunction

    function automatic void check(input bit ok, input string tag, input string what,
                                  input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; indirect = 1'b0; rp = 2'd0; irp = 1'b0;
        doff = 7'd0; ptr = 8'd0; wdata = 8'd0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        clear_model();
    endtask

    // one access: drive at negedge, compare just after, write lands at next posedge
    task automatic access(input bit ind, input logic [1:0] r, input bit ir,
                          input logic [6:0] o, input logic [7:0] p,
                          input bit we, input logic [7:0] wd, input string tag_in);
        int    bank, offs, exp_addr, exp_rd;
        bit    is_sfr, is_shared, is_priv;
        string tag;
        @(negedge clk);
        indirect = ind; rp = r; irp = ir; doff = o; ptr = p; wr_en = we; wdata = wd;
        #1;
        bank      = ind ? {ir, p[7]} : r;
        offs      = ind ? p[6:0] : o;
        is_sfr    = offs < 'h20;
        is_shared = offs >= 'h70;
        is_priv   = !is_sfr && !is_shared && bank < 2;
        exp_addr  = is_mirror(offs) ? offs : (bank * 128 + offs);
        if (is_sfr)         exp_rd = (exp_addr & 'hFF) ^ 'h5A;
        else if (is_shared) exp_rd = shared_m[offs - 'h70];
        else if (is_priv)   exp_rd = priv_m[bank][offs];
        else                exp_rd = 0;
        if (tag_in != "")                  tag = tag_in;
        else if (is_sfr && is_mirror(offs)) tag = "R5";
        else if (is_sfr)                   tag = "R4";
        else if (is_shared)                tag = "R3";
        else if (is_priv)                  tag = "R6";
        else                               tag = "R7";
        check(rdata == exp_rd[7:0], tag, "rdata", rdata, exp_rd);
        check(sfr_sel == is_sfr, tag, "sfr_sel", sfr_sel, is_sfr);
        check(sfr_we == (we && is_sfr), "R10", "sfr_we", sfr_we, we && is_sfr);
        if (is_sfr) begin
            check(sfr_addr == exp_addr[8:0], tag, "sfr_addr", sfr_addr, exp_addr);
            check(sfr_wdata == wd, "R10", "sfr_wdata", sfr_wdata, wd);
        end
        if (we && is_shared)     shared_m[offs - 'h70] = wd;
        else if (we && is_priv)  priv_m[bank][offs] = wd;
    endtask

    task automatic rd_dir(input logic [1:0] r, input logic [6:0] o, input string t);
        access(1'b0, r, 1'b0, o, 8'h00, 1'b0, 8'h00, t);
    endtask

    task automatic wr_dir(input logic [1:0] r, input logic [6:0] o, input logic [7:0] d,
                          input string t);
        access(1'b0, r, 1'b0, o, 8'h00, 1'b1, d, t);
    endtask

    task automatic rd_ind(input bit ir, input logic [7:0] p, input string t);
        access(1'b1, 2'd3, ir, 7'h7F, p, 1'b0, 8'h00, t);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; indirect = 1'b0; rp = 2'd0; irp = 1'b0;
        doff = 7'd0; ptr = 8'd0; wdata = 8'd0;
        clear_model();
        do_reset();

        // R9: state right after reset
        rd_dir(2'd0, 7'h20, "R9");
        rd_dir(2'd1, 7'h6F, "R9");
        rd_dir(2'd2, 7'h70, "R9");

        // R1 / R6: direct mode, private bytes per bank
        wr_dir(2'd0, 7'h40, 8'hA1, "R1");
        wr_dir(2'd1, 7'h40, 8'hB2, "R6");
        rd_dir(2'd0, 7'h40, "R1");
        rd_dir(2'd1, 7'h40, "R6");
        rd_dir(2'd2, 7'h05, "R1");

        // R8: old data during the write cycle, new data after
        wr_dir(2'd0, 7'h21, 8'h11, "R8");
        access(1'b0, 2'd0, 1'b0, 7'h21, 8'h00, 1'b1, 8'h22, "R8");
        rd_dir(2'd0, 7'h21, "R8");

        // R2: indirect bank from irp and pointer bit 7, rp ignored
        rd_ind(1'b0, 8'hC0, "R2");
        rd_ind(1'b0, 8'h40, "R2");
        access(1'b1, 2'd2, 1'b0, 7'h33, 8'hC0, 1'b1, 8'h77, "R2");
        rd_dir(2'd1, 7'h40, "R2");
        rd_dir(2'd2, 7'h33, "R2");
        rd_ind(1'b1, 8'h85, "R2");
        rd_ind(1'b1, 8'h06, "R2");

        // R3: shared area across banks and modes
        wr_dir(2'd3, 7'h75, 8'h5C, "R3");
        rd_dir(2'd0, 7'h75, "R3");
        rd_dir(2'd2, 7'h75, "R3");
        rd_ind(1'b1, 8'hF5, "R3");
        access(1'b1, 2'd0, 1'b0, 7'h00, 8'h7F, 1'b1, 8'hE3, "R3");
        rd_dir(2'd3, 7'h7F, "R3");

        // R4 / R5 / R10: register port, mirrored and plain
        access(1'b0, 2'd2, 1'b0, 7'h05, 8'h00, 1'b1, 8'h99, "R4");
        rd_dir(2'd3, 7'h1F, "R4");
        rd_dir(2'd3, 7'h03, "R5");
        rd_dir(2'd1, 7'h0A, "R5");
        rd_dir(2'd2, 7'h01, "R5");
        rd_ind(1'b1, 8'h8B, "R5");
        wr_dir(2'd1, 7'h20, 8'h3C, "R10");

        // R7: unimplemented private range in banks 2 and 3
        wr_dir(2'd2, 7'h30, 8'hFF, "R7");
        rd_dir(2'd2, 7'h30, "R7");
        wr_dir(2'd3, 7'h6F, 8'hEE, "R7");
        rd_dir(2'd3, 7'h6F, "R7");
        rd_dir(2'd0, 7'h30, "R7");
        rd_dir(2'd1, 7'h6F, "R7");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            access(1'($urandom), 2'($urandom), 1'($urandom), 7'($urandom), 8'($urandom),
                   1'($urandom), 8'($urandom), "");
        end

        // R9: reset after traffic clears everything
        do_reset();
        for (int b = 0; b < 2; b++)
            for (int o = 'h20; o < 'h80; o++) rd_dir(2'(b), 7'(o), "R9");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule